// File: doc/BRIEF.md
# Prefixed instruction pairing decoder

This decode stage sits after a first code lookup. It turns a stream of fetched 32-bit instruction words into a stream of decoded operations. Most words pass straight through. A word whose primary opcode (bits 31:26) is 1 is a prefix. The stage keeps that word and emits nothing for it. The next word it accepts is taken as the suffix, and the pair leaves as a single operation.

For each pair the stage does five things:
- It turns the suffix code into its prefixed variant by setting the code's least significant bit.
- It rebuilds the prefix address from a few low bits saved with the prefix.
- It joins the two displacement fields into a sign-extended 34-bit immediate.
- It decides whether the PC-relative bit counts.
- It checks whether the prefix kind fits the suffix opcode. That check only yields a flag. It never changes the code.

Both sides use valid/ready handshakes. The upstream side accepts a word when the output register is empty or is being drained in the same cycle. A held output (`out_valid` high, `out_ready` low) stalls the stage: `in_ready` drops, and both the output register and any held prefix stay frozen. A flush clears the held prefix and the output register. Any word offered during the flush cycle is discarded.

Top module: `prefix_pair_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An accepted prefix word (bits 31:26 equal 1) arriving while no prefix is held produces no output in the next cycle.
- R2: The first word accepted after a held prefix leaves one cycle later as a paired operation. It has `out_prefixed`=1 and `out_code` equal to the suffix's `in_code` with bit 0 forced to 1. The held prefix is then released.
- R3: A word accepted with no prefix held, and not itself a prefix, leaves one cycle later with the following values: `in_code` unchanged, `in_addr` unchanged, `out_prefixed`=0, `out_legal`=1, `out_pcrel`=0, and `out_imm` equal to the sign extension of word bits 15:0.
- R4: For a pair, `out_addr` takes bits 5:2 from the prefix's fetch address. All other bits come from the suffix's fetch address.
- R5: For a pair, `out_imm` is the 64-bit sign extension of {prefix bits 17:0, suffix bits 15:0}.
- R6: For a pair, `out_pcrel` equals prefix bit 20 when the prefix kind (bits 25:24) is 0 or 2. For kinds 1 and 3 it is 0.
- R7: For a pair, `out_legal` is 1 only in the cases below. A suffix with opcode 1 is always illegal.
  - Kind 0: prefix bits 23:21 and 19:18 are zero, and the suffix opcode is 41, 57 or 61.
  - Kind 2: the same prefix bits are zero, and the suffix opcode is one of 14, 32, 34, 36, 38, 40, 42, 44, 48, 50, 52 or 54.
  - Kind 3: prefix bits 23:20 are zero.
  - Kind 1: never legal.
- R8: The legality result never alters `out_code`. An illegal pair still leaves with the suffix code having bit 0 set. The stand-alone-illegal doubleword suffixes (opcodes 57 and 61) become legal pairs under kind 0.
- R9: Cycles with `in_valid` low between a prefix and its suffix leave the prefix pending.
- R10: `flush` clears the held prefix and `out_valid` at the next edge, and the word offered in that cycle is dropped. The next accepted non-prefix word therefore leaves unpaired.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R12: A prefix word that arrives while a prefix is held is taken as that prefix's suffix. By R7 it is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect: drop held prefix and output |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Stage can take a word |
| in_word | input | 32 | Fetched instruction word |
| in_addr | input | ADDR_W (64) | Fetch address of the word |
| in_code | input | CODE_W (9) | Code from the earlier lookup |
| out_valid | output | 1 | Decoded operation valid |
| out_ready | input | 1 | Downstream accepts the operation |
| out_code | output | CODE_W (9) | Final code (bit 0 set for pairs) |
| out_addr | output | ADDR_W (64) | Operation address (prefix address for pairs) |
| out_prefixed | output | 1 | Operation came from a pair |
| out_legal | output | 1 | Prefix kind fits the suffix |
| out_imm | output | 64 | Sign-extended immediate |
| out_pcrel | output | 1 | PC-relative addressing selected |

## Verification
The hardest situation to reach is a prefix that stays pending while other events happen around it: bubbles, a stalled output, a flush, or a second prefix arriving. Each of these takes a particular ordering of `in_valid`, `out_ready` and `flush` in the cycles between the two words. Directed sequences build each ordering deliberately. A long random phase then mixes prefixes (about a third of words), bubbles, back-pressure and rare flushes. A behavioural model of pending-prefix state is compared against the ports on every clock.

// File: rtl/prefix_pair_pkg.sv
package prefix_pair_pkg;
  localparam logic [5:0] PFX_OPCODE = 6'd1;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PFX_KEEP_W = 26;
  localparam int unsigned PFX_DISP_W = 18;
  localparam int unsigned SFX_DISP_W = 16;
  localparam int unsigned JOIN_W = PFX_DISP_W + SFX_DISP_W;

  typedef enum logic [1:0] {
    KIND_WIDE_LS  = 2'd0,
    KIND_RESERVED = 2'd1,
    KIND_MOD_LS   = 2'd2,
    KIND_MISC     = 2'd3
  } pfx_kind_e;

  function automatic logic word_is_prefix(input logic [WORD_W-1:0] w);
    return w[31:26] == PFX_OPCODE;
  endfunction
endpackage

// File: rtl/prefix_hold.sv
module prefix_hold #(
  parameter int unsigned KEEP_W = 26,
  parameter int unsigned SAVE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              consume,
  input  logic [KEEP_W-1:0] word_in,
  input  logic [SAVE_W-1:0] addr_in,
  output logic              held,
  output logic [KEEP_W-1:0] word_q,
  output logic [SAVE_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      word_q <= '0;
      addr_q <= '0;
    end else if (clear) begin
      held <= 1'b0;
    end else if (capture) begin
      held   <= 1'b1;
      word_q <= word_in;
      addr_q <= addr_in;
    end else if (consume) begin
      held <= 1'b0;
    end
  end

  assert_capture_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clear) |=> held);
  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !held);
endmodule

// File: rtl/pair_legality.sv
module pair_legality
  import prefix_pair_pkg::*;
(
  input  logic [PFX_KEEP_W-1:0] pfx_word,
  input  logic [5:0]            sfx_opcode,
  output logic                  legal,
  output logic                  rel_allowed
);
  pfx_kind_e kind;
  logic      ls_rsvd_clear;
  logic      wide_op_ok;
  logic      mod_op_ok;

  always_comb begin
    kind          = pfx_kind_e'(pfx_word[25:24]);
    ls_rsvd_clear = (pfx_word[23:21] == 3'd0) && (pfx_word[19:18] == 2'd0);
    wide_op_ok    = sfx_opcode inside {6'd41, 6'd57, 6'd61};
    mod_op_ok     = sfx_opcode inside {6'd14, 6'd32, 6'd34, 6'd36, 6'd38, 6'd40,
                                       6'd42, 6'd44, 6'd48, 6'd50, 6'd52, 6'd54};
    rel_allowed   = (kind == KIND_WIDE_LS) || (kind == KIND_MOD_LS);
    unique case (kind)
      KIND_WIDE_LS:  legal = ls_rsvd_clear && wide_op_ok;
      KIND_MOD_LS:   legal = ls_rsvd_clear && mod_op_ok;
      KIND_MISC:     legal = (pfx_word[23:20] == 4'd0);
      default:       legal = 1'b0;
    endcase
    if (sfx_opcode == PFX_OPCODE) legal = 1'b0;
  end
endmodule

// File: rtl/imm_join.sv
module imm_join
  import prefix_pair_pkg::*;
#(
  parameter int unsigned IMM_W = 64
) (
  input  logic                  paired,
  input  logic [PFX_DISP_W-1:0] hi_disp,
  input  logic [SFX_DISP_W-1:0] lo_disp,
  output logic [IMM_W-1:0]      imm
);
  localparam int unsigned LONG_PAD  = IMM_W - JOIN_W;
  localparam int unsigned SHORT_PAD = IMM_W - SFX_DISP_W;

  logic [JOIN_W-1:0] joined;

  always_comb begin
    joined = {hi_disp, lo_disp};
    if (paired) imm = {{LONG_PAD{joined[JOIN_W-1]}}, joined};
    else        imm = {{SHORT_PAD{lo_disp[SFX_DISP_W-1]}}, lo_disp};
  end
endmodule

// File: rtl/prefix_pair_decoder.sv
module prefix_pair_decoder
  import prefix_pair_pkg::*;
#(
  parameter int unsigned CODE_W   = 9,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned IMM_W    = 64,
  parameter int unsigned SPAN_B   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_prefixed,
  output logic              out_legal,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_pcrel
);
  localparam int unsigned SAVE_LO = 2;
  localparam int unsigned SAVE_HI = $clog2(SPAN_B) - 1;
  localparam int unsigned SAVE_W  = SAVE_HI - SAVE_LO + 1;

  logic                  accept, take_pfx, emit, is_pfx;
  logic                  held;
  logic [PFX_KEEP_W-1:0] pfx_q;
  logic [SAVE_W-1:0]     pfx_addr_q;
  logic                  pair_legal, rel_ok;
  logic [IMM_W-1:0]      imm_next;
  logic [ADDR_W-1:0]     addr_next;
  logic [CODE_W-1:0]     code_next;

  assign in_ready = !out_valid || out_ready;
  assign is_pfx   = word_is_prefix(in_word);
  assign accept   = in_valid && in_ready && !flush;
  assign take_pfx = accept && is_pfx && !held;
  assign emit     = accept && !take_pfx;

  prefix_hold #(.KEEP_W(PFX_KEEP_W), .SAVE_W(SAVE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .capture (take_pfx),
    .consume (emit),
    .word_in (in_word[PFX_KEEP_W-1:0]),
    .addr_in (in_addr[SAVE_HI:SAVE_LO]),
    .held    (held),
    .word_q  (pfx_q),
    .addr_q  (pfx_addr_q)
  );

  pair_legality u_legal (
    .pfx_word    (pfx_q),
    .sfx_opcode  (in_word[31:26]),
    .legal       (pair_legal),
    .rel_allowed (rel_ok)
  );

  imm_join #(.IMM_W(IMM_W)) u_imm (
    .paired  (held),
    .hi_disp (pfx_q[PFX_DISP_W-1:0]),
    .lo_disp (in_word[SFX_DISP_W-1:0]),
    .imm     (imm_next)
  );

  always_comb begin
    addr_next = in_addr;
    code_next = in_code;
    if (held) begin
      addr_next[SAVE_HI:SAVE_LO] = pfx_addr_q;
      code_next[0]               = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_code     <= '0;
      out_addr     <= '0;
      out_prefixed <= 1'b0;
      out_legal    <= 1'b0;
      out_imm      <= '0;
      out_pcrel    <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (emit) begin
      out_valid    <= 1'b1;
      out_code     <= code_next;
      out_addr     <= addr_next;
      out_prefixed <= held;
      out_legal    <= held ? pair_legal : 1'b1;
      out_imm      <= imm_next;
      out_pcrel    <= held && rel_ok && pfx_q[20];
    end else if (take_pfx || out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_prefix_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush && is_pfx && !held) |=> !out_valid);
  assert_pair_code_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_prefixed) |-> out_code[0]);
  assert_pcrel_needs_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pcrel) |-> out_prefixed);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_code) && $stable(out_addr) && $stable(out_imm)
       && $stable(out_legal) && $stable(out_pcrel) && $stable(out_prefixed)));
  assert_single_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_prefixed) |-> (out_legal && !out_pcrel));
endmodule

// File: tb/test_prefix_pair_decoder.sv
module test_prefix_pair_decoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic [63:0] in_addr = '0;
  logic [8:0]  in_code = '0;
  logic        in_ready, out_valid, out_prefixed, out_legal, out_pcrel;
  logic [8:0]  out_code;
  logic [63:0] out_addr, out_imm;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_pair_decoder i_prefix_pair_decoder (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_addr(in_addr), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_addr(out_addr),
    .out_prefixed(out_prefixed), .out_legal(out_legal), .out_imm(out_imm),
    .out_pcrel(out_pcrel));

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  string scen = "reset";

  // reference model state
  bit          m_held = 0, m_ov = 0, m_pref = 0, m_legal = 0, m_pcrel = 0;
  logic [31:0] m_pw = '0;
  logic [63:0] m_pa = '0, m_addr = '0, m_imm = '0;
  logic [8:0]  m_code = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", tag, scen, act, exp, $time);
    end
  endtask

  function automatic bit ref_legal(logic [31:0] p, logic [5:0] op);
    bit rs = (p[23:21] == 0) && (p[19:18] == 0);
    if (op == 6'd1) return 0;
    case (p[25:24])
      2'd0: return rs && (op == 41 || op == 57 || op == 61);
      2'd2: return rs && (op == 14 || op == 32 || op == 34 || op == 36 || op == 38 ||
                          op == 40 || op == 42 || op == 44 || op == 48 || op == 50 ||
                          op == 52 || op == 54);
      2'd3: return p[23:20] == 0;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(bit v, logic [31:0] w, logic [63:0] a, logic [8:0] c, bit fl, bit rdy);
    bit acc;
    logic [33:0] j;
    in_valid = v; in_word = w; in_addr = a; in_code = c; flush = fl; out_ready = rdy;
    #1;
    chk("R11 in_ready", {63'd0, in_ready}, {63'd0, (!m_ov || rdy)});
    acc = v && (!m_ov || rdy) && !fl;
    if (fl) begin
      m_held = 0; m_ov = 0;
    end else if (acc) begin
      if (w[31:26] == 6'd1 && !m_held) begin
        m_held = 1; m_pw = w; m_pa = a; m_ov = 0;
      end else begin
        m_ov = 1;
        if (m_held) begin
          j = {m_pw[17:0], w[15:0]};
          m_code = c | 9'd1; m_pref = 1;
          m_addr = {a[63:6], m_pa[5:2], a[1:0]};
          m_imm = {{30{j[33]}}, j};
          m_legal = ref_legal(m_pw, w[31:26]);
          m_pcrel = m_pw[20] && (m_pw[25:24] == 0 || m_pw[25:24] == 2);
        end else begin
          m_code = c; m_pref = 0; m_addr = a; m_legal = 1; m_pcrel = 0;
          m_imm = {{48{w[15]}}, w[15:0]};
        end
        m_held = 0;
      end
    end else if (rdy) m_ov = 0;
    @(negedge clk);
    chk("R1 out_valid", {63'd0, out_valid}, {63'd0, m_ov});
    if (m_ov) begin
      chk("R2 out_code", {55'd0, out_code}, {55'd0, m_code});
      chk("R2 out_prefixed", {63'd0, out_prefixed}, {63'd0, m_pref});
      chk("R4 out_addr", out_addr, m_addr);
      chk("R5 out_imm", out_imm, m_imm);
      chk("R6 out_pcrel", {63'd0, out_pcrel}, {63'd0, m_pcrel});
      chk("R7 out_legal", {63'd0, out_legal}, {63'd0, m_legal});
    end
  endtask

  function automatic logic [31:0] pfx(logic [1:0] kind, logic [3:0] sub, logic [17:0] d);
    return {6'd1, kind, sub, 2'b00, d};
  endfunction
  function automatic logic [31:0] sfx(logic [5:0] op, logic [15:0] d);
    return {op, 10'h155, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    scen = "R1 reset";
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);

    scen = "R3 plain words";
    cyc(1, sfx(6'd32, 16'h8001), 64'h1000, 9'd40, 0, 1);
    cyc(1, sfx(6'd14, 16'h0123), 64'h1004, 9'd7, 0, 1);
    cyc(0, '0, '0, '0, 0, 1);

    scen = "R8 wide doubleword load pair pcrel";
    cyc(1, pfx(2'd0, 4'b0001, 18'h3_0000), 64'h2034, 9'd0, 0, 1);
    cyc(1, sfx(6'd57, 16'hFFF0), 64'h2038, 9'd56, 0, 1);
    scen = "R8 illegal pair keeps odd code";
    cyc(1, pfx(2'd0, 4'b0000, 18'h0_0001), 64'h3008, 9'd0, 0, 1);
    cyc(1, sfx(6'd32, 16'h0004), 64'h300C, 9'd20, 0, 1);

    scen = "R6 modified pair pcrel, misc kind no pcrel";
    cyc(1, pfx(2'd2, 4'b0001, 18'h1_2345), 64'h4010, 9'd0, 0, 1);
    cyc(1, sfx(6'd14, 16'h6789), 64'h4014, 9'd30, 0, 1);
    cyc(1, pfx(2'd3, 4'b0001, 18'h0), 64'h4018, 9'd0, 0, 1);
    cyc(1, sfx(6'd24, 16'h0), 64'h401C, 9'd12, 0, 1);
    cyc(1, pfx(2'd1, 4'b0000, 18'h0), 64'h4020, 9'd0, 0, 1);
    cyc(1, sfx(6'd32, 16'h0), 64'h4024, 9'd20, 0, 1);

    scen = "R9 bubbles between prefix and suffix";
    cyc(1, pfx(2'd2, 4'b0000, 18'h2_0000), 64'h503C - 64'h4, 9'd0, 0, 1);
    repeat (4) cyc(0, 32'hDEAD_BEEF, 64'h0, 9'd0, 0, 1);
    cyc(1, sfx(6'd34, 16'h0010), 64'h503C, 9'd22, 0, 1);

    scen = "R10 flush drops held prefix";
    cyc(1, pfx(2'd2, 4'b0001, 18'h0_0005), 64'h6000, 9'd0, 0, 1);
    cyc(1, sfx(6'd32, 16'h0001), 64'h6004, 9'd20, 1, 1);
    cyc(1, sfx(6'd32, 16'h0002), 64'h7000, 9'd20, 0, 1);

    scen = "R11 stall holds output and prefix";
    cyc(1, sfx(6'd36, 16'h0003), 64'h8000, 9'd24, 0, 0);
    cyc(1, pfx(2'd0, 4'b0001, 18'h0_0007), 64'h8004, 9'd0, 0, 0);
    cyc(1, pfx(2'd0, 4'b0001, 18'h0_0007), 64'h8004, 9'd0, 0, 0);
    cyc(1, pfx(2'd0, 4'b0001, 18'h0_0007), 64'h8004, 9'd0, 0, 1);
    cyc(1, sfx(6'd61, 16'h0008), 64'h8008, 9'd60, 0, 0);
    cyc(0, '0, '0, '0, 0, 0);
    cyc(0, '0, '0, '0, 0, 1);

    scen = "R12 prefix after prefix";
    cyc(1, pfx(2'd3, 4'b0000, 18'h0_0001), 64'h9010, 9'd0, 0, 1);
    cyc(1, pfx(2'd3, 4'b0000, 18'h0_0002), 64'h9014, 9'd2, 0, 1);
    cyc(1, sfx(6'd32, 16'h0), 64'h9018, 9'd20, 0, 1);

    scen = "random mix";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      logic [63:0] a;
      logic [5:0]  ops [6] = '{6'd14, 6'd32, 6'd41, 6'd57, 6'd61, 6'd24};
      a = {$urandom(), $urandom()} & ~64'h3;
      if ($urandom_range(0, 2) == 0)
        w = {6'd1, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3) == 0 ? $urandom() : {3'b000, 1'($urandom())}), 2'($urandom_range(0, 5) == 0), 18'($urandom())};
      else
        w = {ops[$urandom_range(0, 5)], 26'($urandom())};
      cyc($urandom_range(0, 3) != 0, w, a, 9'($urandom()) & 9'h1FE,
          $urandom_range(0, 40) == 0, $urandom_range(0, 3) != 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule